// File: doc/BRIEF.md
# Serial Channel-Command and Fault-Report Slave

This block is the serial front end of an eight-channel output switch controller. A host master talks to it over a four-wire SPI link in mode 0 (clock idle low, data sampled on rising SCK, SDO changed on falling SCK, most significant bit first). Each transfer does two things at once. It carries a command word inward whose bits switch the eight channels on or off. It carries a fault word outward that reports latched per-channel overtemperature events, three status levels, a protocol-error bit and a parity code. A mode input chooses 8-bit or 16-bit frames. Frames longer than one word pass through to SDO, so several devices can share one daisy chain.

The SPI pins are asynchronous to the system clock. Each pin passes through a two-flop synchroniser with edge detection, so the serial clock must be several times slower than the system clock. When SS_n falls, the block freezes a snapshot of the fault word for the whole transfer. When SS_n rises, it looks only at the last 8 or 16 bits received. In 16-bit mode it checks the bit count and a four-bit parity code. A frame that fails either check is rejected and raises a protocol-error flag. The combined active-low fault output goes low while any overtemperature flag or the protocol-error flag is set. A global disable input forces every channel off without stopping the serial interface.

Top module: `spi_chan_slave`

## Requirements
- R1: SDI is sampled on synchronised SCK rising edges and SDO changes only after SCK falling edges. Both directions are MSB first.
- R2: `sdo_oe` is 0 while SS_n is high and 1 during a transfer. The first bit the master samples is the MSB of the fault frame.
- R3: The fault word is captured when SS_n falls. An overtemperature pulse that arrives later in the same transfer does not appear in that frame.
- R4: When SS_n rises, only the last frame-length bits shifted in are evaluated. When more bits are clocked, the frame-length fault bits leave SDO first, followed by the earliest SDI bits in order.
- R5: 16-bit command layout, MSB first: bits 15..8 are the channel bits C7..C0, bits 7..4 are ignored, and bits 3..0 are {P2,P1,P0,nP0}. P0 is the XOR of C7..C0, P1 the XOR of C1,C3,C5,C7, P2 the XOR of C0,C2,C4,C6, and nP0 = ~P0. An accepted frame sets `chan_en[i]` = Ci.
- R6: 16-bit fault layout, MSB first: F7..F0, fbok, twarn, PC, pg, P2, P1, P0, nP0. P0 is the XOR of F7..F0, P1 the XOR of PC, fbok, F1, F3, F5, F7, P2 the XOR of pg, twarn, F0, F2, F4, F6, and nP0 = ~P0. In 8-bit mode the fault frame is F7..F0.
- R7: An `ot_evt[i]` pulse sets flag Fi, which holds until the end of an accepted frame. Only flags that were in that frame's snapshot are then cleared.
- R8: In 8-bit mode there is no parity. The last 8 bits map directly to C7..C0.
- R9: A transfer with at least one SCK rising edge is rejected in either of two cases: the count is not a multiple of 8, or it is below the frame length. A 16-bit frame is also rejected when its parity code mismatches. A rejection sets PC. An accepted frame clears PC. A transfer with no SCK edges changes nothing.
- R10: A rejected frame leaves `chan_en` unchanged.
- R11: While `chan_off` is 1, `chan_en` is 0. Shifting, flag latching and command acceptance continue, and the stored enables reappear when `chan_off` returns to 0.
- R12: `fault_n` is 0 exactly when any flag F7..F0 or PC is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock (asynchronous) |
| ss_n | input | 1 | Slave select, active low (asynchronous) |
| sdi | input | 1 | Serial data in |
| mode16 | input | 1 | 1 = 16-bit frames, 0 = 8-bit frames; sampled at SS_n fall |
| chan_off | input | 1 | Global channel disable |
| ot_evt | input | 8 | Per-channel overtemperature pulses, clk domain |
| st_fbok | input | 1 | Status level reported in the fault frame |
| st_twarn | input | 1 | Case-warning status level |
| st_pg | input | 1 | Supply-good status level |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | SDO drive enable (tri-state control) |
| chan_en | output | 8 | Channel enables |
| fault_n | output | 1 | Combined fault, active low |

## Verification
Well-formed 16-bit and 8-bit frames with random channel patterns and random status levels check the command mapping and the fault-frame parity code, because every flag and status bit feeds a different parity term. Frames whose nP0 bit is flipped are told apart from good ones only by the parity check. Transfers of 12, 5 or 8 bits in 16-bit mode separate a wrong count from a short count. Transfers of 24 and 32 bits expose the daisy-chain ordering on SDO. An overtemperature pulse injected in the middle of a transfer separates the frozen snapshot from the live flags. Toggling the global disable around a good frame shows that the stored enables survive it.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;
  localparam int NCH     = 8;
  localparam int FRAME_W = 16;
  localparam int HALF_W  = FRAME_W / 2;

  // parity nibble {P2,P1,P0,nP0} protecting a channel command byte
  function automatic logic [3:0] cmd_code(input logic [NCH-1:0] c);
    logic p0, p1, p2;
    p0 = ^c;
    p1 = c[1] ^ c[3] ^ c[5] ^ c[7];
    p2 = c[0] ^ c[2] ^ c[4] ^ c[6];
    return {p2, p1, p0, ~p0};
  endfunction

  // full 16-bit report word
  function automatic logic [FRAME_W-1:0] flt_word(input logic [NCH-1:0] f,
                                                  input logic fbok, input logic twarn,
                                                  input logic pc, input logic pg);
    logic p0, p1, p2;
    p0 = ^f;
    p1 = pc ^ fbok ^ f[1] ^ f[3] ^ f[5] ^ f[7];
    p2 = pg ^ twarn ^ f[0] ^ f[2] ^ f[4] ^ f[6];
    return {f, fbok, twarn, pc, pg, p2, p1, p0, ~p0};
  endfunction
endpackage

// File: rtl/scs_sync.sv
module scs_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  localparam int LAST = STAGES;

  logic [W-1:0] pipe_q [LAST+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= LAST; i++) pipe_q[i] <= RST_VAL;
    end else begin
      pipe_q[0] <= din;
      for (int i = 1; i <= LAST; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign lvl  = pipe_q[LAST-1];
  assign rise = pipe_q[LAST-1] & ~pipe_q[LAST];
  assign fall = ~pipe_q[LAST-1] & pipe_q[LAST];
endmodule

// File: rtl/scs_shift.sv
module scs_shift
  import spi_chan_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_rise,
  input  logic               sck_fall,
  input  logic               ss_fall,
  input  logic               sdi_b,
  input  logic               mode16_in,
  input  logic [FRAME_W-1:0] load_word,
  output logic [FRAME_W-1:0] rx_word,
  output logic               mode16_q,
  output logic               len_ok,
  output logic               any_bit,
  output logic               sdo
);
  localparam int CW = $clog2(FRAME_W) + 1;

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CW-1:0]      nb_q, nb_d;
  logic [2:0]         m8_q, m8_d;
  logic               mode_d, sdo_q, sdo_d;

  always_comb begin
    sr_d   = sr_q;
    nb_d   = nb_q;
    m8_d   = m8_q;
    mode_d = mode16_q;
    sdo_d  = sdo_q;
    if (ss_fall) begin
      sr_d   = load_word;
      nb_d   = '0;
      m8_d   = '0;
      mode_d = mode16_in;
      sdo_d  = mode16_in ? load_word[FRAME_W-1] : load_word[HALF_W-1];
    end else begin
      if (sck_rise) begin
        sr_d = {sr_q[FRAME_W-2:0], sdi_b};
        m8_d = m8_q + 3'd1;
        if (nb_q != CW'(FRAME_W)) nb_d = nb_q + 1'b1;
      end
      if (sck_fall) sdo_d = mode16_q ? sr_q[FRAME_W-1] : sr_q[HALF_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= '0;
      nb_q     <= '0;
      m8_q     <= '0;
      mode16_q <= 1'b0;
      sdo_q    <= 1'b0;
    end else begin
      sr_q     <= sr_d;
      nb_q     <= nb_d;
      m8_q     <= m8_d;
      mode16_q <= mode_d;
      sdo_q    <= sdo_d;
    end
  end

  assign rx_word = sr_q;
  assign sdo     = sdo_q;
  assign any_bit = (nb_q != '0);
  assign len_ok  = (m8_q == 3'd0) &&
                   (nb_q >= (mode16_q ? CW'(FRAME_W) : CW'(HALF_W)));
endmodule

// File: rtl/scs_ctrl.sv
module scs_ctrl
  import spi_chan_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ss_fall,
  input  logic               ss_rise,
  input  logic               any_bit,
  input  logic               len_ok,
  input  logic               mode16_q,
  input  logic [FRAME_W-1:0] rx_word,
  input  logic [NCH-1:0]     ot_evt,
  output logic [NCH-1:0]     chan_q,
  output logic [NCH-1:0]     ot_q,
  output logic               pc_q
);
  logic [NCH-1:0] snap_q, snap_d, chan_d, ot_d, cmd;
  logic           pc_d, par_ok, accept, reject;

  always_comb begin
    cmd    = mode16_q ? rx_word[FRAME_W-1:HALF_W] : rx_word[HALF_W-1:0];
    par_ok = !mode16_q || (rx_word[3:0] == cmd_code(rx_word[FRAME_W-1:HALF_W]));
    accept = ss_rise && any_bit && len_ok && par_ok;
    reject = ss_rise && any_bit && !(len_ok && par_ok);
    snap_d = ss_fall ? ot_q : snap_q;
    ot_d   = (ot_q & ~(accept ? snap_q : '0)) | ot_evt;
    chan_d = accept ? cmd : chan_q;
    pc_d   = accept ? 1'b0 : (reject ? 1'b1 : pc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      ot_q   <= '0;
      chan_q <= '0;
      pc_q   <= 1'b0;
    end else begin
      snap_q <= snap_d;
      ot_q   <= ot_d;
      chan_q <= chan_d;
      pc_q   <= pc_d;
    end
  end
endmodule

// File: rtl/spi_chan_slave.sv
module spi_chan_slave
  import spi_chan_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sck,
  input  logic           ss_n,
  input  logic           sdi,
  input  logic           mode16,
  input  logic           chan_off,
  input  logic [NCH-1:0] ot_evt,
  input  logic           st_fbok,
  input  logic           st_twarn,
  input  logic           st_pg,
  output logic           sdo,
  output logic           sdo_oe,
  output logic [NCH-1:0] chan_en,
  output logic           fault_n
);
  logic [2:0]         s_lvl, s_rise, s_fall;
  logic               ss_lvl, ss_fall, ss_rise, sck_rise, sck_fall;
  logic [FRAME_W-1:0] rx_word, load_word;
  logic               mode16_q, len_ok, any_bit, pc_q;
  logic [NCH-1:0]     chan_q, ot_q;

  // bit order {sdi, ss_n, sck}; ss_n idles high
  scs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sdi, ss_n, sck}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  assign ss_lvl   = s_lvl[1];
  assign ss_fall  = s_fall[1];
  assign ss_rise  = s_rise[1];
  assign sck_rise = s_rise[0] & ~ss_lvl;
  assign sck_fall = s_fall[0] & ~ss_lvl;

  assign load_word = mode16 ? flt_word(ot_q, st_fbok, st_twarn, pc_q, st_pg)
                            : {{HALF_W{1'b0}}, ot_q};

  scs_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .ss_fall(ss_fall), .sdi_b(s_lvl[2]), .mode16_in(mode16), .load_word(load_word),
    .rx_word(rx_word), .mode16_q(mode16_q), .len_ok(len_ok), .any_bit(any_bit),
    .sdo(sdo)
  );

  scs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ss_fall(ss_fall), .ss_rise(ss_rise),
    .any_bit(any_bit), .len_ok(len_ok), .mode16_q(mode16_q), .rx_word(rx_word),
    .ot_evt(ot_evt), .chan_q(chan_q), .ot_q(ot_q), .pc_q(pc_q)
  );

  assign sdo_oe  = ~ss_lvl;
  assign chan_en = chan_q & {NCH{~chan_off}};
  assign fault_n = ~((|ot_q) | pc_q);
endmodule

// File: rtl/spi_chan_slave_chk.sv
module spi_chan_slave_chk
  import spi_chan_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           chan_off,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] chan_q,
  input logic [NCH-1:0] ot_evt,
  input logic [NCH-1:0] ot_q,
  input logic           pc_q,
  input logic           ss_rise
);
  AST_DISABLE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    chan_off |-> (chan_en == '0)); // R11

  AST_ENABLES_CHANGE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_rise |=> $stable(chan_q)); // R10

  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_evt != '0) |=> ((ot_q & $past(ot_evt)) == $past(ot_evt))); // R7

  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_rise |=> ((ot_q & $past(ot_q)) == $past(ot_q))); // R7

  AST_PC_RAISED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pc_q) |-> $past(ss_rise)); // R9
endmodule

bind spi_chan_slave spi_chan_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chan_off(chan_off), .chan_en(chan_en),
  .chan_q(chan_q), .ot_evt(ot_evt), .ot_q(ot_q), .pc_q(pc_q), .ss_rise(ss_rise)
);

// File: tb/sim_spi_chan_slave.sv
module sim_spi_chan_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HSCK       = 8;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sck = 1'b0, ss_n = 1'b1, sdi = 1'b0, mode16 = 1'b1, chan_off = 1'b0;
  logic [7:0] ot_evt = 8'h00;
  logic       st_fbok = 1'b0, st_twarn = 1'b0, st_pg = 1'b0;
  logic       sdo, sdo_oe, fault_n;
  logic [7:0] chan_en;

  int  checks = 0, fails = 0;
  bit  done = 0;

  logic [7:0] m_chan = 8'h00, m_ot = 8'h00;
  logic       m_pc = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_chan_slave u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .sdi(sdi), .mode16(mode16),
    .chan_off(chan_off), .ot_evt(ot_evt), .st_fbok(st_fbok), .st_twarn(st_twarn),
    .st_pg(st_pg), .sdo(sdo), .sdo_oe(sdo_oe), .chan_en(chan_en), .fault_n(fault_n)
  );

  function automatic logic [3:0] b_code(input logic [7:0] c);
    logic a;
    a = ^c;
    return {c[0]^c[2]^c[4]^c[6], c[1]^c[3]^c[5]^c[7], a, ~a};
  endfunction

  function automatic logic [15:0] b_fault(input logic [7:0] f, input logic fb,
                                          input logic tw, input logic pc, input logic pg);
    logic a;
    a = ^f;
    return {f, fb, tw, pc, pg, pg^tw^f[0]^f[2]^f[4]^f[6], pc^fb^f[1]^f[3]^f[5]^f[7], a, ~a};
  endfunction

  function automatic logic [15:0] b_cmd(input logic [7:0] c, input bit corrupt);
    return {c, 4'h0, b_code(c) ^ {3'b000, corrupt}};
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk) ot_evt = m;
    @(negedge clk) ot_evt = 8'h00;
    m_ot |= m;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_outs(input string tag);
    chk({tag, " R11 R5"}, "chan_en", chan_en, chan_off ? 8'h00 : m_chan);
    chk("R12 R9", "fault_n", fault_n, !((m_ot != 0) || m_pc));
  endtask

  task automatic xfer(input int n, input logic m16, input logic [31:0] tx_in, input logic [7:0] mid_evt);
    logic [31:0] tx;
    logic [63:0] rx, expv, mask, fw;
    logic [7:0]  snap, cmd;
    int          fl;
    bit          good;
    tx   = (n >= 32) ? tx_in : (tx_in & ((32'h1 << n) - 1));
    fl   = m16 ? 16 : 8;
    @(negedge clk) mode16 = m16;
    snap = m_ot;
    fw   = m16 ? {48'h0, b_fault(m_ot, st_fbok, st_twarn, m_pc, st_pg)} : {56'h0, m_ot};
    chk("R2", "sdo_oe idle", sdo_oe, 0);
    ss_n = 1'b0;
    repeat (HSCK) @(negedge clk);
    chk("R2", "sdo_oe active", sdo_oe, 1);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      sdi = tx[n-1-i];
      repeat (HSCK) @(negedge clk);
      sck = 1'b1;
      rx  = {rx[62:0], sdo};
      if (i == 3 && mid_evt != 0) begin
        ot_evt = mid_evt;
        @(negedge clk) ot_evt = 8'h00;
        m_ot |= mid_evt;
        repeat (HSCK-1) @(negedge clk);
      end else begin
        repeat (HSCK) @(negedge clk);
      end
      sck = 1'b0;
    end
    repeat (HSCK) @(negedge clk);
    ss_n = 1'b1;
    repeat (HSCK) @(negedge clk);
    if (n > 0) begin
      mask = (64'h1 << n) - 1;
      if (n >= fl) expv = (fw << (n - fl)) | ({32'h0, tx} >> fl);
      else         expv = fw >> (fl - n);
      chk("R1 R2 R3 R4 R6", "sdo stream", rx & mask, expv & mask);
      cmd  = m16 ? tx[15:8] : tx[7:0];
      good = (n % 8 == 0) && (n >= fl) && (!m16 || tx[3:0] == b_code(tx[15:8]));
      if (good) begin
        m_chan = cmd;
        m_ot   = m_ot & ~snap;
        m_pc   = 1'b0;
      end else begin
        m_pc = 1'b1;
      end
    end
    check_outs(m16 ? "R10" : "R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5", "reset chan_en", chan_en, 0);
    chk("R12", "reset fault_n", fault_n, 1);
    chk("R2", "reset sdo_oe", sdo_oe, 0);

    xfer(16, 1'b1, {16'h0, b_cmd(8'hA5, 0)}, 8'h00);        // R5 good frame
    xfer(16, 1'b1, {16'h0, b_cmd(8'h3C, 1)}, 8'h00);        // R10 parity error
    xfer(16, 1'b1, {16'h0, b_cmd(8'h3C, 0)}, 8'h00);        // PC cleared
    xfer(12, 1'b1, 32'h00000ABC, 8'h00);                    // R9 not multiple of 8
    xfer(8,  1'b0, 32'h0000005A, 8'h00);                    // R8 byte mode
    xfer(8,  1'b1, 32'h000000FF, 8'h00);                    // R9 short 16-bit frame
    xfer(0,  1'b1, 32'h0, 8'h00);                           // R9 no clocks
    pulse(8'h81);
    xfer(16, 1'b1, {16'h0, b_cmd(8'h0F, 0)}, 8'h10);        // R3 R7 mid-transfer event
    xfer(24, 1'b1, {8'hC3, b_cmd(8'h99, 0)}, 8'h00);        // R4 daisy chain
    xfer(32, 1'b1, {16'hBEEF, b_cmd(8'h66, 0)}, 8'h00);     // R4 two extra bytes
    pulse(8'h22);
    xfer(8,  1'b0, 32'h000000F0, 8'h00);                    // R7 R8 clear in byte mode

    @(negedge clk) chan_off = 1'b1;                         // R11
    repeat (2) @(negedge clk);
    chk("R11", "chan_en forced off", chan_en, 0);
    xfer(16, 1'b1, {16'h0, b_cmd(8'h7E, 0)}, 8'h04);
    @(negedge clk) chan_off = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11", "chan_en restored", chan_en, 8'h7E);

    for (int k = 0; k < 40; k++) begin
      int          n;
      logic        m;
      logic [31:0] t;
      int          sel;
      sel = $urandom % 8;
      n   = (sel < 5) ? (8 * (1 + $urandom % 4)) : (1 + $urandom % 31);
      m   = $urandom % 2;
      t   = $urandom;
      if (m && ($urandom % 4 != 0)) t[15:0] = b_cmd(t[15:8], 0);
      st_fbok  = $urandom % 2;
      st_twarn = $urandom % 2;
      st_pg    = $urandom % 2;
      if ($urandom % 3 == 0) pulse(8'($urandom));
      xfer(n, m, t, ($urandom % 5 == 0) ? 8'($urandom) : 8'h00);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule